// File: doc/BRIEF.md
# Firewall Packet Verdict Unit

This block decides what happens to each packet before the processor core touches it. For every packet it receives a parsed header and a flag from an upstream signature matcher. A packet whose payload matched no signature is passed on for ordinary processing. A packet that did match is looked up by source IPv4 address in two small content-addressable lists. One list holds trusted addresses and the other holds blocked addresses. The result is a two-bit action word held in a register. Software reads this word while it processes the packet.

A signature hit whose address is in neither list is not dropped. It is marked for redirection to a remote controller. The controller then answers with instruction packets. These carry an add or remove request for one of the two lists, so the lists are maintained in-band without any register access.

Top module: `fw_verdict_unit`

## Requirements
- R1: After reset the action word is 2'b00 and both lists are empty, so a signature packet from any address is given 2'b11.
- R2: The action word changes only on the clock edge where `pkt_start` is high and holds its value in every other cycle, whatever the other inputs do.
- R3: A data packet (`is_ctrl` low) with `sig_hit` low gets 2'b00 (normal), even if its address is in either list.
- R4: A data packet with `sig_hit` high whose source address is in the allow list and not in the deny list gets 2'b01 (allow).
- R5: A data packet with `sig_hit` high whose source address is in the deny list gets 2'b10 (drop), including when the address is also in the allow list.
- R6: A data packet with `sig_hit` high whose source address is in neither list gets 2'b11 (redirect to controller).
- R7: An instruction packet (`is_ctrl` high) gets 2'b00 whatever `sig_hit` is. It applies one update selected by `upd_list` (0 = allow list, 1 = deny list) and `upd_op` (0 = add, 1 = remove) for `upd_addr`. The update is done in that clock edge and is seen by every packet that starts later.
- R8: An add stores the address in the lowest-numbered free entry of the 16-entry list. An add to a full list is ignored, and an entry freed by a remove is reused.
- R9: Adding an address that is already in the list stores no second copy, so a single remove afterwards takes the address out of that list.
- R10: Update fields have no effect on a data packet, and removing an address that is not in a list leaves that list unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | One-cycle strobe marking a new parsed header |
| src_ip | input | 32 | Source IPv4 address of the packet |
| sig_hit | input | 1 | Payload matched a configured signature |
| is_ctrl | input | 1 | Packet is an instruction packet from the controller |
| upd_list | input | 1 | List to update: 0 allow, 1 deny |
| upd_op | input | 1 | Update kind: 0 add, 1 remove |
| upd_addr | input | 32 | Address to add or remove |
| action_word | output | 2 | Registered verdict: 00 normal, 01 allow, 10 drop, 11 redirect |

## Verification
The verdict is tested with the same source addresses in every list state: in no list, in allow only, in deny only, and in both. The tests also use `sig_hit` both low and high, so an error in the lookup, in the deny priority, or in the gating by the signature flag gives a different code. Instruction packets are sent with `sig_hit` high, and data packets are sent with live update fields. These separate packets that should update from packets that should be classified. Fill, overflow, duplicate-add and remove-then-reuse sequences test the free-entry selection and the valid bits. The bench also changes the inputs between strobes to check that the action is held.

// File: rtl/fw_verdict_pkg.sv
package fw_verdict_pkg;

    typedef enum logic [1:0] {
        ACT_NORMAL   = 2'b00,
        ACT_ALLOW    = 2'b01,
        ACT_DROP     = 2'b10,
        ACT_REDIRECT = 2'b11
    } fw_action_e;

    typedef enum logic {
        LIST_ALLOW = 1'b0,
        LIST_DENY  = 1'b1
    } fw_list_e;

    typedef enum logic {
        OP_ADD    = 1'b0,
        OP_REMOVE = 1'b1
    } fw_op_e;

    localparam int NUM_LISTS = 2;

    typedef struct packed {
        logic sig;
        logic allow;
        logic deny;
    } fw_lookup_t;

    // Deny wins over allow; no signature means ordinary processing.
    function automatic fw_action_e resolve_action(fw_lookup_t l);
        if (!l.sig)       return ACT_NORMAL;
        else if (l.deny)  return ACT_DROP;
        else if (l.allow) return ACT_ALLOW;
        else              return ACT_REDIRECT;
    endfunction

endpackage

// File: rtl/fw_addr_cam.sv
module fw_addr_cam
    import fw_verdict_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int KEY_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [KEY_W-1:0] lk_key,
    output logic             lk_hit,
    input  logic             wr_en,
    input  fw_op_e           wr_op,
    input  logic [KEY_W-1:0] wr_key
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [KEY_W-1:0] key_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] lk_match;
    logic [DEPTH-1:0] wr_match;
    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic             do_add;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign lk_match[g] = vld_q[g] && (key_q[g] == lk_key);
        assign wr_match[g] = vld_q[g] && (key_q[g] == wr_key);
    end

    assign lk_hit = |lk_match;

    // Lowest free slot: scan downward so the smallest index wins.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign do_add = wr_en && (wr_op == OP_ADD) && !(|wr_match) && free_found;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (do_add) begin
            vld_q[free_idx] <= 1'b1;
        end else if (wr_en && (wr_op == OP_REMOVE)) begin
            vld_q <= vld_q & ~wr_match;
        end
    end

    always_ff @(posedge clk) begin
        if (do_add) key_q[free_idx] <= wr_key;
    end

endmodule

// File: rtl/fw_update_decode.sv
module fw_update_decode
    import fw_verdict_pkg::*;
(
    input  logic                 pkt_start,
    input  logic                 is_ctrl,
    input  fw_list_e             upd_list,
    output logic [NUM_LISTS-1:0] list_wr_en
);
    logic ctrl_pkt;
    assign ctrl_pkt = pkt_start && is_ctrl;

    for (genvar l = 0; l < NUM_LISTS; l++) begin : g_sel
        assign list_wr_en[l] = ctrl_pkt && (upd_list == fw_list_e'(l));
    end
endmodule

// File: rtl/fw_verdict_core.sv
module fw_verdict_core
    import fw_verdict_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pkt_start,
    input  logic       is_ctrl,
    input  logic       sig_hit,
    input  logic       allow_hit,
    input  logic       deny_hit,
    output fw_action_e action_q
);
    fw_lookup_t lk;
    fw_action_e action_d;

    always_comb begin
        lk.sig   = sig_hit;
        lk.allow = allow_hit;
        lk.deny  = deny_hit;
        action_d = is_ctrl ? ACT_NORMAL : resolve_action(lk);
    end

    always_ff @(posedge clk) begin
        if (rst)            action_q <= ACT_NORMAL;
        else if (pkt_start) action_q <= action_d;
    end
endmodule

// File: rtl/fw_verdict_unit.sv
module fw_verdict_unit
    import fw_verdict_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LIST_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_start,
    input  logic [ADDR_W-1:0] src_ip,
    input  logic              sig_hit,
    input  logic              is_ctrl,
    input  logic              upd_list,
    input  logic              upd_op,
    input  logic [ADDR_W-1:0] upd_addr,
    output logic [1:0]        action_word
);
    logic [NUM_LISTS-1:0] list_wr_en;
    logic [NUM_LISTS-1:0] list_hit;
    logic                 allow_hit;
    logic                 deny_hit;
    fw_action_e           action_q;

    fw_update_decode u_dec (
        .pkt_start  (pkt_start),
        .is_ctrl    (is_ctrl),
        .upd_list   (fw_list_e'(upd_list)),
        .list_wr_en (list_wr_en)
    );

    for (genvar l = 0; l < NUM_LISTS; l++) begin : g_list
        fw_addr_cam #(
            .DEPTH (LIST_DEPTH),
            .KEY_W (ADDR_W)
        ) u_cam (
            .clk    (clk),
            .rst    (rst),
            .lk_key (src_ip),
            .lk_hit (list_hit[l]),
            .wr_en  (list_wr_en[l]),
            .wr_op  (fw_op_e'(upd_op)),
            .wr_key (upd_addr)
        );
    end

    assign allow_hit = list_hit[LIST_ALLOW];
    assign deny_hit  = list_hit[LIST_DENY];

    fw_verdict_core u_core (
        .clk       (clk),
        .rst       (rst),
        .pkt_start (pkt_start),
        .is_ctrl   (is_ctrl),
        .sig_hit   (sig_hit),
        .allow_hit (allow_hit),
        .deny_hit  (deny_hit),
        .action_q  (action_q)
    );

    assign action_word = action_q;
endmodule

// File: rtl/fw_verdict_chk.sv
module fw_verdict_chk (
    input logic       clk,
    input logic       rst,
    input logic       pkt_start,
    input logic       is_ctrl,
    input logic       sig_hit,
    input logic       allow_hit,
    input logic       deny_hit,
    input logic [1:0] action_word
);
    // R2
    action_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pkt_start |=> $stable(action_word));

    // R3
    normal_path_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_start && !is_ctrl && !sig_hit) |=> (action_word == 2'b00));

    // R7
    ctrl_normal_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_start && is_ctrl) |=> (action_word == 2'b00));

    // R5
    deny_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_start && !is_ctrl && sig_hit && deny_hit) |=> (action_word == 2'b10));

    // R4
    allow_path_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_start && !is_ctrl && sig_hit && allow_hit && !deny_hit) |=> (action_word == 2'b01));

    // R6
    redirect_path_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_start && !is_ctrl && sig_hit && !allow_hit && !deny_hit) |=> (action_word == 2'b11));
endmodule

bind fw_verdict_unit fw_verdict_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pkt_start   (pkt_start),
    .is_ctrl     (is_ctrl),
    .sig_hit     (sig_hit),
    .allow_hit   (allow_hit),
    .deny_hit    (deny_hit),
    .action_word (action_word)
);

// File: tb/fw_verdict_unit_tb.sv
module fw_verdict_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_start = 1'b0;
    logic [31:0] src_ip = '0;
    logic        sig_hit = 1'b0;
    logic        is_ctrl = 1'b0;
    logic        upd_list = 1'b0;
    logic        upd_op = 1'b0;
    logic [31:0] upd_addr = '0;
    logic [1:0]  action_word;

    int total = 0;
    int fails = 0;

    localparam logic [1:0] NRM = 2'b00, ALW = 2'b01, DRP = 2'b10, RDR = 2'b11;
    localparam logic [31:0] IP_A = 32'h0A000001, IP_B = 32'h0A000002,
                            IP_C = 32'h0A000003, IP_D = 32'h0A000004,
                            IP_E = 32'h0A000005, IP_F = 32'h0A000006;

    always #10 clk = ~clk;

    fw_verdict_unit u_dut (
        .clk(clk), .rst(rst), .pkt_start(pkt_start), .src_ip(src_ip),
        .sig_hit(sig_hit), .is_ctrl(is_ctrl), .upd_list(upd_list),
        .upd_op(upd_op), .upd_addr(upd_addr), .action_word(action_word)
    );

    task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, got, exp);
        end
    endtask

    // Drive one header at a negedge; return at the next negedge, after the loading edge.
    task automatic send(input logic [31:0] ip, input logic sig, input logic ctrl,
                        input logic lst, input logic op, input logic [31:0] ua);
        src_ip = ip; sig_hit = sig; is_ctrl = ctrl;
        upd_list = lst; upd_op = op; upd_addr = ua;
        pkt_start = 1'b1;
        @(negedge clk);
        pkt_start = 1'b0;
    endtask

    task automatic data_pkt(input logic [31:0] ip, input logic sig);
        send(ip, sig, 1'b0, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic ctrl_pkt(input logic lst, input logic op, input logic [31:0] ua);
        send(32'hFFFF_FFFF, 1'b1, 1'b1, lst, op, ua);
    endtask

    task automatic t_reset;
        check("R1 reset action", action_word, NRM);
        data_pkt(IP_A, 1'b1);
        check("R1 empty lists redirect", action_word, RDR);
    endtask

    task automatic t_hold;
        data_pkt(IP_C, 1'b1);
        for (int i = 0; i < 4; i++) begin
            src_ip = IP_A + i; sig_hit = i[0]; is_ctrl = i[1];
            @(negedge clk);
        end
        sig_hit = 1'b0; is_ctrl = 1'b0;
        check("R2 held between strobes", action_word, RDR);
    endtask

    task automatic t_normal;
        ctrl_pkt(1'b1, 1'b0, IP_A);
        data_pkt(IP_A, 1'b0);
        check("R3 no signature in deny list", action_word, NRM);
        data_pkt(IP_C, 1'b0);
        check("R3 no signature unknown", action_word, NRM);
    endtask

    task automatic t_allow;
        ctrl_pkt(1'b0, 1'b0, IP_B);
        data_pkt(IP_B, 1'b1);
        check("R4 allow listed", action_word, ALW);
    endtask

    task automatic t_deny;
        data_pkt(IP_A, 1'b1);
        check("R5 deny listed", action_word, DRP);
        ctrl_pkt(1'b0, 1'b0, IP_A);
        data_pkt(IP_A, 1'b1);
        check("R5 both lists deny wins", action_word, DRP);
        data_pkt(IP_D, 1'b1);
        check("R6 neither list", action_word, RDR);
    endtask

    task automatic t_ctrl;
        data_pkt(IP_D, 1'b1);
        ctrl_pkt(1'b0, 1'b1, IP_B);
        check("R7 instruction packet normal", action_word, NRM);
        data_pkt(IP_B, 1'b1);
        check("R7 remove seen by next packet", action_word, RDR);
        ctrl_pkt(1'b1, 1'b0, IP_B);
        data_pkt(IP_B, 1'b1);
        check("R7 deny add seen by next packet", action_word, DRP);
    endtask

    task automatic t_ignore;
        send(IP_C, 1'b0, 1'b0, 1'b0, 1'b0, IP_C);
        data_pkt(IP_C, 1'b1);
        check("R10 update fields on data packet", action_word, RDR);
        ctrl_pkt(1'b1, 1'b1, IP_D);
        data_pkt(IP_A, 1'b1);
        check("R10 remove absent keeps deny", action_word, DRP);
    endtask

    task automatic t_dup;
        ctrl_pkt(1'b0, 1'b0, IP_E);
        ctrl_pkt(1'b0, 1'b0, IP_E);
        data_pkt(IP_E, 1'b1);
        check("R9 duplicate add allowed", action_word, ALW);
        ctrl_pkt(1'b0, 1'b1, IP_E);
        data_pkt(IP_E, 1'b1);
        check("R9 single remove clears", action_word, RDR);
    endtask

    task automatic t_full;
        ctrl_pkt(1'b0, 1'b1, IP_A);
        for (int i = 0; i < 16; i++) ctrl_pkt(1'b0, 1'b0, 32'h0B000000 + i);
        ctrl_pkt(1'b0, 1'b0, IP_F);
        data_pkt(IP_F, 1'b1);
        check("R8 add to full list ignored", action_word, RDR);
        data_pkt(32'h0B00000F, 1'b1);
        check("R8 sixteenth entry held", action_word, ALW);
        ctrl_pkt(1'b0, 1'b1, 32'h0B000005);
        ctrl_pkt(1'b0, 1'b0, IP_F);
        data_pkt(IP_F, 1'b1);
        check("R8 freed entry reused", action_word, ALW);
        data_pkt(32'h0B000005, 1'b1);
        check("R8 removed entry gone", action_word, RDR);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_hold();
        t_normal();
        t_allow();
        t_deny();
        t_ctrl();
        t_ignore();
        t_dup();
        t_full();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule